// File: doc/BRIEF.md
# Center-Aligned Dead-Time PWM Channel

This block is a single timer channel that produces a center-aligned PWM waveform with a dead-time interval inserted on either its leading or its trailing edge. It watches a shared up/down (triangle) counter bus as its main time base and owns a private dead-time counter. One compare value holds the ideal duty point; a second holds the dead-time length. Each output edge is placed by moving the duty comparison between the shared triangle counter and the private counter, which the channel clears at the relevant duty match. With leading insertion the effective pulse shrinks by the dead time, and with trailing insertion it grows by the same amount.

Software or a supervising block can inject force strobes that behave like comparator hits, and a freeze input lets those strobes only set the output level. A sticky event flag marks the trailing edge of each pulse, or both edges, depending on a mode bit. Pulses continue whether or not the flag has been cleared.

Top module: `dtpwm_channel`

## Requirements
- R1: While rst_ni is low, pwm_o is 0 and flag_o is 0.
- R2: While en_i is low, on the first cycle en_i is high after being low, and on any cycle where lead_mode_i or pol_i differs from its value in the previous cycle, the sequence returns to its first phase (waiting for a duty match) and pwm_o becomes the inverse of pol_i.
- R3: With lead_mode_i = 1 the channel cycles through three phases: a duty match clears the private counter and enters the dead phase; the dead-time match drives pwm_o to pol_i and re-arms the duty compare; the next duty match drives pwm_o to the inverse of pol_i and returns to the first phase.
- R4: With lead_mode_i = 0 the channel cycles through three phases: a duty match drives pwm_o to pol_i; the next duty match clears the private counter and enters the dead phase; the dead-time match drives pwm_o to the inverse of pol_i and returns to the first phase.
- R5: A duty match occurs on a cycle with tick_i = 1 and bus_cnt_i equal to duty_i, outside the dead phase; during the dead phase duty matches have no effect.
- R6: The private counter is cleared to 0 on entering the dead phase and rises by one on each tick, saturating at all ones; a dead-time match occurs in the dead phase on a tick where the counter equals dead_i.
- R7: With flag_both_i = 0 the flag is set only by a match that drives pwm_o to the inverse of pol_i.
- R8: With flag_both_i = 1 the flag is also set by a match that drives pwm_o to pol_i.
- R9: flag_o stays set until a cycle with flag_clr_i = 1 clears it; when a set and a clear fall on the same cycle, flag_o is 1 afterwards.
- R10: force_a_i (outside the dead phase) and force_b_i (inside the dead phase) act like a duty and dead-time match respectively, advancing the sequence, but never set the flag; force_b_i outside and force_a_i inside the dead phase have no effect.
- R11: While freeze_i = 1, ticks are ignored, the phase and counter hold, force_b_i drives pwm_o to pol_i when lead_mode_i = 1 (inverse otherwise) and force_a_i drives pwm_o to the inverse of pol_i when lead_mode_i = 1 (pol_i otherwise); force_b_i wins if both are high.
- R12: pwm_o and flag_o are registered and show the effect of the inputs one clock edge after those inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Channel enable |
| tick_i | input | 1 | Shared prescaler tick |
| freeze_i | input | 1 | Debug freeze |
| lead_mode_i | input | 1 | 1: leading-edge dead time, 0: trailing-edge |
| pol_i | input | 1 | Active output level of the pulse |
| flag_both_i | input | 1 | 1: flag on both edges, 0: trailing edge only |
| duty_i | input | CNT_W | Duty compare value |
| dead_i | input | CNT_W | Dead-time compare value |
| bus_cnt_i | input | CNT_W | Shared up/down counter bus |
| force_a_i | input | 1 | Force duty comparator event |
| force_b_i | input | 1 | Force dead-time comparator event |
| flag_clr_i | input | 1 | Flag clear strobe |
| pwm_o | output | 1 | PWM output |
| flag_o | output | 1 | Sticky event flag |

## Verification
Every result of this block, output level and flag alike, is due exactly one rising edge after the inputs that cause it are sampled, since both outputs come straight from registers and the comparators feed them combinationally. The bench changes inputs and the triangle counter on the falling edge, advances a behavioural model on the rising edge, and compares both outputs with the model on the following falling edge, so each comparison lands half a cycle after the edge where the result must appear. Dead-time matches land the counted number of ticks after the clearing duty match, and the model counts those ticks itself.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_DEAD   = 2'd2
  } phase_e;
endpackage

// File: rtl/dtpwm_dead_cnt.sv
module dtpwm_dead_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clr_i)                    cnt_o <= '0;
    else if (tick_i && cnt_o != CntMax) cnt_o <= cnt_o + 1'b1; // saturate
  end
endmodule

// File: rtl/dtpwm_seq.sv
module dtpwm_seq
  import dtpwm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   idle_i,
  input  logic   freeze_i,
  input  logic   lead_i,
  input  logic   pol_i,
  input  logic   both_i,
  input  logic   match_a_i,
  input  logic   match_b_i,
  input  logic   force_a_i,
  input  logic   force_b_i,
  output phase_e phase_o,
  output logic   pwm_o,
  output logic   cnt_clr_o,
  output logic   flag_set_o
);
  phase_e phase_d;
  logic   pwm_d;
  logic   ev_a, ev_b;
  logic   lead_edge, trail_edge, by_match;

  assign ev_a = (phase_o != PH_DEAD) && (match_a_i || force_a_i);
  assign ev_b = (phase_o == PH_DEAD) && (match_b_i || force_b_i);

  always_comb begin
    phase_d    = phase_o;
    pwm_d      = pwm_o;
    cnt_clr_o  = 1'b0;
    lead_edge  = 1'b0;
    trail_edge = 1'b0;
    by_match   = 1'b0;
    if (idle_i) begin
      phase_d = PH_FIRST;
      pwm_d   = ~pol_i;
    end else if (freeze_i) begin
      if (force_b_i)      pwm_d = lead_i ? pol_i : ~pol_i;
      else if (force_a_i) pwm_d = lead_i ? ~pol_i : pol_i;
    end else if (lead_i) begin
      unique case (phase_o)
        PH_FIRST: if (ev_a) begin
          cnt_clr_o = 1'b1;
          phase_d   = PH_DEAD;
        end
        PH_DEAD: if (ev_b) begin
          pwm_d     = pol_i;
          phase_d   = PH_SECOND;
          lead_edge = 1'b1;
          by_match  = match_b_i;
        end
        PH_SECOND: if (ev_a) begin
          pwm_d      = ~pol_i;
          phase_d    = PH_FIRST;
          trail_edge = 1'b1;
          by_match   = match_a_i;
        end
        default: phase_d = PH_FIRST;
      endcase
    end else begin
      unique case (phase_o)
        PH_FIRST: if (ev_a) begin
          pwm_d     = pol_i;
          phase_d   = PH_SECOND;
          lead_edge = 1'b1;
          by_match  = match_a_i;
        end
        PH_SECOND: if (ev_a) begin
          cnt_clr_o = 1'b1;
          phase_d   = PH_DEAD;
        end
        PH_DEAD: if (ev_b) begin
          pwm_d      = ~pol_i;
          phase_d    = PH_FIRST;
          trail_edge = 1'b1;
          by_match   = match_b_i;
        end
        default: phase_d = PH_FIRST;
      endcase
    end
    flag_set_o = by_match && (trail_edge || (lead_edge && both_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_FIRST;
      pwm_o   <= 1'b0;
    end else begin
      phase_o <= phase_d;
      pwm_o   <= pwm_d;
    end
  end
endmodule

// File: rtl/dtpwm_flag.sv
module dtpwm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1; // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/dtpwm_channel.sv
module dtpwm_channel
  import dtpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             lead_mode_i,
  input  logic             pol_i,
  input  logic             flag_both_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] bus_cnt_i,
  input  logic             force_a_i,
  input  logic             force_b_i,
  input  logic             flag_clr_i,
  output logic             pwm_o,
  output logic             flag_o
);
  logic             en_q, lead_q, pol_q;
  logic             restart, idle, tick_run;
  logic             match_a, match_b;
  logic             cnt_clr, flag_set;
  logic [CNT_W-1:0] cnt_q;
  phase_e           phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lead_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      en_q   <= en_i;
      lead_q <= lead_mode_i;
      pol_q  <= pol_i;
    end
  end

  assign restart  = en_i && (!en_q || lead_mode_i != lead_q || pol_i != pol_q);
  assign idle     = !en_i || restart;
  assign tick_run = tick_i && !idle && !freeze_i;
  assign match_a  = tick_run && phase_q != PH_DEAD && bus_cnt_i == duty_i;
  assign match_b  = tick_run && phase_q == PH_DEAD && cnt_q == dead_i;

  dtpwm_dead_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (tick_run),
    .cnt_o  (cnt_q)
  );

  dtpwm_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (idle),
    .freeze_i   (freeze_i),
    .lead_i     (lead_mode_i),
    .pol_i      (pol_i),
    .both_i     (flag_both_i),
    .match_a_i  (match_a),
    .match_b_i  (match_b),
    .force_a_i  (force_a_i),
    .force_b_i  (force_b_i),
    .phase_o    (phase_q),
    .pwm_o      (pwm_o),
    .cnt_clr_o  (cnt_clr),
    .flag_set_o (flag_set)
  );

  dtpwm_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );
endmodule

// File: rtl/dtpwm_channel_chk.sv
module dtpwm_channel_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pol_i,
  input logic             freeze_i,
  input logic             tick_i,
  input logic             flag_clr_i,
  input logic             pwm_o,
  input logic             flag_o,
  input logic             flag_set,
  input logic             restart,
  input logic             cnt_clr,
  input logic [1:0]       phase_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pwm_o == !$past(pol_i)); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !flag_set |=> !flag_o); // R9
  AST_NO_TICK_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !flag_o |=> !flag_o); // R10
  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CntMax && !cnt_clr |=> cnt_q == CntMax); // R6
  AST_FREEZE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && freeze_i && !restart |=> $stable(phase_q)); // R11
  AST_FREEZE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && freeze_i |=> $stable(cnt_q)); // R11
endmodule

bind dtpwm_channel dtpwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .pol_i      (pol_i),
  .freeze_i   (freeze_i),
  .tick_i     (tick_i),
  .flag_clr_i (flag_clr_i),
  .pwm_o      (pwm_o),
  .flag_o     (flag_o),
  .flag_set   (flag_set),
  .restart    (restart),
  .cnt_clr    (cnt_clr),
  .phase_q    (phase_q),
  .cnt_q      (cnt_q)
);

// File: tb/dtpwm_channel_bench.sv
`timescale 1ns/1ps
module dtpwm_channel_bench;
  localparam int W = 8;
  localparam int MAXV = 255;
  localparam int TOP = 31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, tick = 0, frz = 0, lead = 0, pol = 0, both = 0;
  logic fa = 0, fb = 0, fclr = 0;
  logic [W-1:0] duty = 0, dead = 0, bus = 0;
  logic pwm, flag;

  int checks = 0, errors = 0, cycles = 0;
  logic cmp_on = 0, bus_run = 0, bus_up = 1, tick_on = 0;
  string cur_req = "R1";

  // model state
  logic m_pwm, m_flag, m_en, m_lead, m_pol;
  int   m_ph, m_cnt;

  always #4 clk = ~clk; // 125 MHz

  dtpwm_channel #(.CNT_W(W)) u_dtpwm_channel (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .freeze_i(frz),
    .lead_mode_i(lead), .pol_i(pol), .flag_both_i(both), .duty_i(duty),
    .dead_i(dead), .bus_cnt_i(bus), .force_a_i(fa), .force_b_i(fb),
    .flag_clr_i(fclr), .pwm_o(pwm), .flag_o(flag)
  );

  // triangle bus and tick
  always @(negedge clk) begin
    tick <= tick_on;
    if (bus_run) begin
      if (bus_up) begin
        if (int'(bus) == TOP - 1) bus_up <= 0;
        bus <= bus + 1'b1;
      end else begin
        if (int'(bus) == 1) bus_up <= 1;
        bus <= bus - 1'b1;
      end
    end
  end

  // behavioural reference, advanced at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwm = 0; m_flag = 0; m_en = 0; m_lead = 0; m_pol = 0; m_ph = 0; m_cnt = 0;
    end else begin
      logic rs, ma, mb, ea, eb, setf, clrc;
      int   nph;
      rs = en && (!m_en || lead != m_lead || pol != m_pol);
      m_en = en; m_lead = lead; m_pol = pol;
      setf = 0; clrc = 0; nph = m_ph;
      if (!en || rs) begin
        nph = 0; m_pwm = !pol;
      end else if (frz) begin
        if (fb)      m_pwm = lead ? pol : !pol;
        else if (fa) m_pwm = lead ? !pol : pol;
      end else begin
        ma = tick && m_ph != 2 && bus == duty;
        mb = tick && m_ph == 2 && m_cnt == int'(dead);
        ea = m_ph != 2 && (ma || fa);
        eb = m_ph == 2 && (mb || fb);
        if (lead) begin
          if (m_ph == 0 && ea) begin clrc = 1; nph = 2; end
          else if (m_ph == 2 && eb) begin m_pwm = pol; nph = 1; setf = mb && both; end
          else if (m_ph == 1 && ea) begin m_pwm = !pol; nph = 0; setf = ma; end
        end else begin
          if (m_ph == 0 && ea) begin m_pwm = pol; nph = 1; setf = ma && both; end
          else if (m_ph == 1 && ea) begin clrc = 1; nph = 2; end
          else if (m_ph == 2 && eb) begin m_pwm = !pol; nph = 0; setf = mb; end
        end
        if (clrc) m_cnt = 0;
        else if (tick && m_cnt < MAXV) m_cnt = m_cnt + 1;
      end
      m_ph = nph;
      if (fclr) m_flag = 0;
      if (setf) m_flag = 1;
    end
  end

  // per-cycle comparison, half a cycle after the edge (R12)
  always @(negedge clk) begin
    if (cmp_on) begin
      checks += 2;
      if (pwm !== m_pwm) begin
        errors++;
        $display("FAIL %s pwm_o t=%0t actual=%b expected=%b", cur_req, $time, pwm, m_pwm);
      end
      if (flag !== m_flag) begin
        errors++;
        $display("FAIL %s flag_o t=%0t actual=%b expected=%b", cur_req, $time, flag, m_flag);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R12 watchdog expired actual=%0d expected<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    fa = 1; run(1); fa = 0; run(2);
  endtask

  task automatic pulse_b();
    fb = 1; run(1); fb = 0; run(2);
  endtask

  initial begin
    run(3);
    // R1: reset state
    checks++;
    if (pwm !== 1'b0 || flag !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%b%b expected=00", pwm, flag);
    end
    rst_n = 1; run(1);
    cmp_on = 1;

    // R2: disabled level follows inverse polarity
    cur_req = "R2"; pol = 1; run(4); pol = 0; run(4);

    // R3/R5/R6/R7: leading dead time, flag on trailing edge only
    cur_req = "R3"; lead = 1; pol = 1; duty = 20; dead = 4; both = 0;
    tick_on = 1; bus_run = 1; en = 1;
    run(200);
    cur_req = "R7"; fclr = 1; run(1); fclr = 0; run(130);

    // R8: flags on both edges; clear held high to hit set/clear collisions (R9)
    cur_req = "R8"; both = 1; fclr = 1; run(1); fclr = 0; run(70);
    cur_req = "R9"; fclr = 1; run(130); fclr = 0; run(20);

    // R4/R2: trailing mode (mode change restarts)
    cur_req = "R4"; lead = 0; duty = 10; dead = 6; both = 0; run(260);
    cur_req = "R5"; pol = 0; duty = 25; dead = 2; run(200);

    // R10: forces with timebase stopped
    cur_req = "R10"; tick_on = 0; bus_run = 0; bus = 3; duty = 10; fclr = 1; run(2); fclr = 0;
    en = 0; run(2); en = 1; run(2);
    pulse_b(); pulse_a(); pulse_b(); pulse_a(); pulse_a(); pulse_b(); pulse_a();
    lead = 1; run(2);
    pulse_b(); pulse_a(); pulse_a(); pulse_b(); pulse_a(); pulse_a(); pulse_a(); pulse_b();

    // R11: freeze, ticks ignored, forces only set level
    cur_req = "R11"; tick_on = 1; bus_run = 1; duty = 12; dead = 3; run(70);
    frz = 1; run(80);
    pulse_a(); pulse_b(); pulse_a(); fa = 1; fb = 1; run(1); fa = 0; fb = 0; run(2);
    lead = 0; run(2); pulse_a(); pulse_b();
    frz = 0; run(150);

    // R6: saturation, stale dead value must not match after passing it
    cur_req = "R6"; lead = 0; pol = 1; duty = 10; dead = 250; run(100);
    dead = 3; run(400);
    dead = 255; run(300);

    // R2: disable mid-pulse
    cur_req = "R2"; en = 0; run(10); en = 1; run(100);

    cmp_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule